// File: doc/BRIEF.md
# SMBus Host Controller Front End

This block is the host side of a system management bus controller. A processor-side register port of sixteen byte offsets holds status, control, command, target address, two data bytes and a port into a 32-entry block buffer. Software fills in the command and address registers, then writes the control register with the START bit and a protocol code. A sequencer then runs the whole transfer as a series of byte-level operations (start plus address, send, receive, stop) on a simple byte engine, which owns the wire timing. The outcome is posted in the status register.

The sequencer has these states. IDLE waits for an accepted START and goes to ADDR. ADDR issues a start with the address byte. On a missing acknowledge it goes to STOP. Otherwise quick goes to STOP, byte goes to RLO or WLO, and the other protocols go to CMD. CMD sends the command byte. A read then goes to RADDR, a block write to WCNT, and any other write to WLO. WLO sends data0, then goes to WHI for word or to STOP. WHI sends data1 and goes to STOP. WCNT sends the count and goes to WBLK, or to STOP when the count is zero. WBLK sends buffer entries until the last one, then goes to STOP. RADDR is a repeated start with the read address: on a missing acknowledge it goes to STOP, a block read goes to RCNT, and the others go to RLO. RLO receives data0, then goes to RHI for word or to STOP. RHI receives data1 and goes to STOP. RCNT receives the count and goes to RBLK, or to STOP when it is zero. RBLK fills the buffer until the last entry, then goes to STOP. STOP issues a stop, posts the result and returns to IDLE.

Top module: `smbus_host_ctrl`

## Requirements
- R1: Offsets are status 0, control 2, command 3, address 4, data0 5, data1 6 and block port 7. Every register resets to 0, and the unused offsets (1, 8 to 15) read 0.
- R2: Writing status clears each of bits 1 to 4 that is written as 1. Bits written as 0 are unchanged, and writing bit 0 does not clear busy.
- R3: Control bit 6 (START) is never stored and always reads 0. The other seven bits read back as written.
- R4: Control bits 4:2 choose the protocol: 0 quick, 1 byte, 2 byte-data, 3 word-data, 5 block. A START with code 4, 6 or 7 does nothing: status stays as it was and no engine operation is issued.
- R5: Address bit 0 selects read (1) or write (0), and bits 7:1 are the target. Quick and byte transfers put that bit in the first address byte. Byte-data, word and block transfers send the address with bit 0 clear, then the command, then, for a read, a repeated start with bit 0 set.
- R6: Word transfers carry data0 as the low byte (first on the bus) and data1 as the high byte.
- R7: Block transfers use data0 as the byte count, sent after the command on a write and taken from the first received byte on a read. Counts above 32 are cut to 32 entries, and a count of 0 moves no data bytes.
- R8: Each read or write at offset 7 uses the entry at the host index and then advances it, wrapping from 31 to 0. Reading control resets the index to 0.
- R9: An accepted START sets status to exactly 0x01 (busy). On completion status becomes 0x02, or 0x04 on an address error. Bits 0 to 2 are never set together.
- R10: If either address phase is not acknowledged, the next operation is STOP and status ends at 0x04. No command or data byte is sent.
- R11: A write to control while busy is ignored entirely, including its START bit.
- R12: The engine receives one single-cycle request per operation. The last byte received in a read is flagged for a not-acknowledge, and no earlier byte is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (needed for read side effects) |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| eng_op_valid | output | 1 | One-cycle request to the byte engine |
| eng_op | output | 2 | Operation: 0 start+address, 1 send, 2 receive, 3 stop |
| eng_tx | output | 8 | Byte to send (address byte for a start) |
| eng_nack | output | 1 | On receive: answer the byte with a not-acknowledge |
| eng_done | input | 1 | One-cycle completion of the pending operation |
| eng_ack | input | 1 | Acknowledge seen for a start or send |
| eng_rx | input | 8 | Byte received, valid with eng_done |

## Verification
The hardest states to reach from the ports are the block paths at their limits. These are a received count above the buffer size, which must stop after exactly 32 entries and a single not-acknowledge, and the host index wrapping while the sequencer keeps its own counter. The bench reaches them through a target model it owns. The model is loaded with a chosen count byte before each run and counts every engine operation, every stop and every not-acknowledge. The bench then sweeps every supported protocol against both directions and both present and absent targets, and predicts the operation count and the data for each combination arithmetically.

// File: rtl/smbus_host_pkg.sv
package smbus_host_pkg;

    // register offsets
    localparam int unsigned OFF_STAT = 0;
    localparam int unsigned OFF_CTL  = 2;
    localparam int unsigned OFF_CMD  = 3;
    localparam int unsigned OFF_ADDR = 4;
    localparam int unsigned OFF_D0   = 5;
    localparam int unsigned OFF_D1   = 6;
    localparam int unsigned OFF_BLK  = 7;

    localparam logic [7:0] START_BIT = 8'h40;
    localparam logic [7:0] W1C_MASK  = 8'h1E;
    localparam logic [7:0] ST_BUSY   = 8'h01;
    localparam logic [7:0] ST_OK     = 8'h02;
    localparam logic [7:0] ST_DEVERR = 8'h04;

    localparam logic [2:0] PROTO_QUICK = 3'd0;
    localparam logic [2:0] PROTO_BYTE  = 3'd1;
    localparam logic [2:0] PROTO_BDATA = 3'd2;
    localparam logic [2:0] PROTO_WORD  = 3'd3;
    localparam logic [2:0] PROTO_BLOCK = 3'd5;

    typedef enum logic [1:0] {
        ENG_START = 2'd0,
        ENG_SEND  = 2'd1,
        ENG_RECV  = 2'd2,
        ENG_STOP  = 2'd3
    } eng_op_e;

    typedef enum logic [3:0] {
        SQ_IDLE, SQ_ADDR, SQ_CMD, SQ_WLO, SQ_WHI, SQ_WCNT, SQ_WBLK,
        SQ_RADDR, SQ_RLO, SQ_RHI, SQ_RCNT, SQ_RBLK, SQ_STOP
    } seq_state_e;

    function automatic logic proto_supported(input logic [2:0] p);
        return (p == PROTO_QUICK) || (p == PROTO_BYTE) || (p == PROTO_BDATA) ||
               (p == PROTO_WORD)  || (p == PROTO_BLOCK);
    endfunction

endpackage

// File: rtl/smbus_blk_buf.sv
module smbus_blk_buf #(
    parameter  int DEPTH = 32,
    parameter  int DW    = 8,
    localparam int IW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_we,
    input  logic          host_step,
    input  logic          host_clr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    input  logic          seq_we,
    input  logic [IW-1:0] seq_idx,
    input  logic [DW-1:0] seq_wdata,
    output logic [DW-1:0] seq_rdata
);

    logic [IW-1:0] hidx_q;
    logic [DW-1:0] mem_q [DEPTH];

    // host index: cleared by a control read, wraps after the last entry
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hidx_q <= '0;
        else if (host_clr)
            hidx_q <= '0;
        else if (host_step)
            hidx_q <= (hidx_q == IW'(DEPTH - 1)) ? '0 : hidx_q + 1'b1;
    end

    // storage: the sequencer write wins over a host write to the same entry
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (seq_we && seq_idx == IW'(i))
                    mem_q[i] <= seq_wdata;
                else if (host_we && hidx_q == IW'(i))
                    mem_q[i] <= host_wdata;
            end
        end
    end

    assign host_rdata = mem_q[hidx_q];
    assign seq_rdata  = mem_q[seq_idx];

endmodule

// File: rtl/smbus_seq.sv
module smbus_seq
    import smbus_host_pkg::*;
#(
    parameter  int DEPTH = 32,
    localparam int IW    = $clog2(DEPTH),
    localparam int LW    = IW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [2:0]    proto,
    input  logic          rd_mode,
    input  logic [6:0]    dev_addr,
    input  logic [7:0]    cmd_byte,
    input  logic [7:0]    data0,
    input  logic [7:0]    data1,
    input  logic [7:0]    buf_rdata,
    output logic [IW-1:0] buf_idx,
    output logic          buf_we,
    output logic          d0_we,
    output logic          d1_we,
    output logic          done,
    output logic          err,
    output logic          eng_op_valid,
    output logic [1:0]    eng_op,
    output logic [7:0]    eng_tx,
    output logic          eng_nack,
    input  logic          eng_done,
    input  logic          eng_ack,
    input  logic [7:0]    eng_rx
);

    seq_state_e    state, nxt;
    logic          wait_q, err_q;
    logic [IW-1:0] bcnt;
    logic [LW-1:0] blen;
    eng_op_e       op;
    logic          fin, blk_last;

    function automatic logic [LW-1:0] clamp_len(input logic [7:0] n);
        if (int'(n) > DEPTH) return LW'(DEPTH);
        return LW'(n);
    endfunction

    assign fin      = wait_q && eng_done;
    assign blk_last = (LW'(bcnt) == blen - LW'(1));

    // next state, taken when the pending operation completes
    always_comb begin
        nxt = state;
        unique case (state)
            SQ_IDLE:  nxt = SQ_IDLE;
            SQ_ADDR:  if (!eng_ack)                nxt = SQ_STOP;
                      else if (proto == PROTO_QUICK) nxt = SQ_STOP;
                      else if (proto == PROTO_BYTE)  nxt = rd_mode ? SQ_RLO : SQ_WLO;
                      else                           nxt = SQ_CMD;
            SQ_CMD:   if (rd_mode)                 nxt = SQ_RADDR;
                      else if (proto == PROTO_BLOCK) nxt = SQ_WCNT;
                      else                           nxt = SQ_WLO;
            SQ_WLO:   nxt = (proto == PROTO_WORD) ? SQ_WHI : SQ_STOP;
            SQ_WHI:   nxt = SQ_STOP;
            SQ_WCNT:  nxt = (clamp_len(data0) == '0) ? SQ_STOP : SQ_WBLK;
            SQ_WBLK:  nxt = blk_last ? SQ_STOP : SQ_WBLK;
            SQ_RADDR: if (!eng_ack)                nxt = SQ_STOP;
                      else if (proto == PROTO_BLOCK) nxt = SQ_RCNT;
                      else                           nxt = SQ_RLO;
            SQ_RLO:   nxt = (proto == PROTO_WORD) ? SQ_RHI : SQ_STOP;
            SQ_RHI:   nxt = SQ_STOP;
            SQ_RCNT:  nxt = (clamp_len(eng_rx) == '0) ? SQ_STOP : SQ_RBLK;
            SQ_RBLK:  nxt = blk_last ? SQ_STOP : SQ_RBLK;
            SQ_STOP:  nxt = SQ_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= SQ_IDLE;
            wait_q <= 1'b0;
            err_q  <= 1'b0;
            bcnt   <= '0;
            blen   <= '0;
        end else if (state == SQ_IDLE) begin
            wait_q <= 1'b0;
            if (go) begin
                state <= SQ_ADDR;
                err_q <= 1'b0;
            end
        end else if (!wait_q) begin
            wait_q <= 1'b1;
        end else if (eng_done) begin
            wait_q <= 1'b0;
            state  <= nxt;
            if ((state == SQ_ADDR || state == SQ_RADDR) && !eng_ack) err_q <= 1'b1;
            if (state == SQ_WCNT) blen <= clamp_len(data0);
            if (state == SQ_RCNT) blen <= clamp_len(eng_rx);
            if (state == SQ_WBLK || state == SQ_RBLK) bcnt <= bcnt + 1'b1;
            else                                      bcnt <= '0;
        end
    end

    // outputs
    always_comb begin
        op       = ENG_STOP;
        eng_tx   = '0;
        eng_nack = 1'b0;
        unique case (state)
            SQ_IDLE:  ;
            SQ_ADDR:  begin
                          op     = ENG_START;
                          eng_tx = {dev_addr, rd_mode && (proto == PROTO_QUICK || proto == PROTO_BYTE)};
                      end
            SQ_CMD:   begin op = ENG_SEND; eng_tx = cmd_byte;  end
            SQ_WLO:   begin op = ENG_SEND; eng_tx = data0;     end
            SQ_WHI:   begin op = ENG_SEND; eng_tx = data1;     end
            SQ_WCNT:  begin op = ENG_SEND; eng_tx = data0;     end
            SQ_WBLK:  begin op = ENG_SEND; eng_tx = buf_rdata; end
            SQ_RADDR: begin op = ENG_START; eng_tx = {dev_addr, 1'b1}; end
            SQ_RLO:   begin op = ENG_RECV; eng_nack = (proto != PROTO_WORD); end
            SQ_RHI:   begin op = ENG_RECV; eng_nack = 1'b1; end
            SQ_RCNT:  begin op = ENG_RECV; eng_nack = 1'b0; end
            SQ_RBLK:  begin op = ENG_RECV; eng_nack = blk_last; end
            SQ_STOP:  op = ENG_STOP;
        endcase
    end

    assign eng_op       = op;
    assign eng_op_valid = (state != SQ_IDLE) && !wait_q;
    assign buf_idx      = bcnt;
    assign buf_we       = fin && (state == SQ_RBLK);
    assign d0_we        = fin && (state == SQ_RLO || state == SQ_RCNT);
    assign d1_we        = fin && (state == SQ_RHI);
    assign done         = fin && (state == SQ_STOP);
    assign err          = err_q;

endmodule

// File: rtl/smbus_host_ctrl.sv
module smbus_host_ctrl
    import smbus_host_pkg::*;
#(
    parameter  int BUF_DEPTH = 32,
    parameter  int AW        = 4,
    localparam int IW        = $clog2(BUF_DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [AW-1:0] reg_addr,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    output logic          eng_op_valid,
    output logic [1:0]    eng_op,
    output logic [7:0]    eng_tx,
    output logic          eng_nack,
    input  logic          eng_done,
    input  logic          eng_ack,
    input  logic [7:0]    eng_rx
);

    logic [7:0] stat_q, ctl_q, cmd_q, addr_q, d0_q, d1_q;
    logic       busy, go;
    logic       hit_stat, hit_ctl, hit_cmd, hit_addr, hit_d0, hit_d1, hit_blk;
    logic [7:0] host_rdata, seq_rdata;
    logic [IW-1:0] seq_idx;
    logic       seq_buf_we, seq_d0_we, seq_d1_we, seq_done, seq_err;

    assign busy     = stat_q[0];
    assign hit_stat = (reg_addr == AW'(OFF_STAT));
    assign hit_ctl  = (reg_addr == AW'(OFF_CTL));
    assign hit_cmd  = (reg_addr == AW'(OFF_CMD));
    assign hit_addr = (reg_addr == AW'(OFF_ADDR));
    assign hit_d0   = (reg_addr == AW'(OFF_D0));
    assign hit_d1   = (reg_addr == AW'(OFF_D1));
    assign hit_blk  = (reg_addr == AW'(OFF_BLK));

    assign go = reg_wr && hit_ctl && !busy && reg_wdata[6] && proto_supported(reg_wdata[4:2]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
            ctl_q  <= '0;
            cmd_q  <= '0;
            addr_q <= '0;
            d0_q   <= '0;
            d1_q   <= '0;
        end else begin
            if (go)
                stat_q <= ST_BUSY;
            else if (seq_done)
                stat_q <= seq_err ? ST_DEVERR : ST_OK;
            else if (reg_wr && hit_stat)
                stat_q <= stat_q & ~(reg_wdata & W1C_MASK);
            if (reg_wr && hit_ctl && !busy) ctl_q <= reg_wdata & ~START_BIT;
            if (reg_wr && hit_cmd)  cmd_q  <= reg_wdata;
            if (reg_wr && hit_addr) addr_q <= reg_wdata;
            if (seq_d0_we)               d0_q <= eng_rx;
            else if (reg_wr && hit_d0)   d0_q <= reg_wdata;
            if (seq_d1_we)               d1_q <= eng_rx;
            else if (reg_wr && hit_d1)   d1_q <= reg_wdata;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (hit_stat)      reg_rdata = stat_q;
        else if (hit_ctl)  reg_rdata = ctl_q;
        else if (hit_cmd)  reg_rdata = cmd_q;
        else if (hit_addr) reg_rdata = addr_q;
        else if (hit_d0)   reg_rdata = d0_q;
        else if (hit_d1)   reg_rdata = d1_q;
        else if (hit_blk)  reg_rdata = host_rdata;
    end

    smbus_blk_buf #(.DEPTH(BUF_DEPTH), .DW(8)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (reg_wr && hit_blk),
        .host_step  ((reg_wr || reg_rd) && hit_blk),
        .host_clr   (reg_rd && hit_ctl),
        .host_wdata (reg_wdata),
        .host_rdata (host_rdata),
        .seq_we     (seq_buf_we),
        .seq_idx    (seq_idx),
        .seq_wdata  (eng_rx),
        .seq_rdata  (seq_rdata)
    );

    smbus_seq #(.DEPTH(BUF_DEPTH)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .go           (go),
        .proto        (ctl_q[4:2]),
        .rd_mode      (addr_q[0]),
        .dev_addr     (addr_q[7:1]),
        .cmd_byte     (cmd_q),
        .data0        (d0_q),
        .data1        (d1_q),
        .buf_rdata    (seq_rdata),
        .buf_idx      (seq_idx),
        .buf_we       (seq_buf_we),
        .d0_we        (seq_d0_we),
        .d1_we        (seq_d1_we),
        .done         (seq_done),
        .err          (seq_err),
        .eng_op_valid (eng_op_valid),
        .eng_op       (eng_op),
        .eng_tx       (eng_tx),
        .eng_nack     (eng_nack),
        .eng_done     (eng_done),
        .eng_ack      (eng_ack),
        .eng_rx       (eng_rx)
    );

endmodule

// File: rtl/smbus_host_ctrl_chk.sv
module smbus_host_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       eng_op_valid,
    input logic [1:0] eng_op,
    input logic       eng_done,
    input logic       eng_ack,
    input logic       reg_rd,
    input logic [3:0] reg_addr,
    input logic [7:0] reg_rdata,
    input logic [7:0] stat_q,
    input logic [7:0] ctl_q
);

    p_op_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        eng_op_valid |=> !eng_op_valid);

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_q[0] |-> !eng_op_valid);

    p_status_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(stat_q[2:0]));

    p_nack_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && !eng_ack && eng_op == 2'd0) |=> (eng_op_valid && eng_op == 2'd3));

    p_ctl_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        stat_q[0] |=> $stable(ctl_q));

    p_start_reads_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 4'd2) |-> !reg_rdata[6]);

endmodule

bind smbus_host_ctrl smbus_host_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .eng_op_valid (eng_op_valid),
    .eng_op       (eng_op),
    .eng_done     (eng_done),
    .eng_ack      (eng_ack),
    .reg_rd       (reg_rd),
    .reg_addr     (reg_addr),
    .reg_rdata    (reg_rdata),
    .stat_q       (stat_q),
    .ctl_q        (ctl_q)
);

// File: tb/smbus_host_ctrl_test.sv
module smbus_host_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       eng_op_valid, eng_nack;
    logic [1:0] eng_op;
    logic [7:0] eng_tx;
    logic       eng_done = 1'b0, eng_ack = 1'b0;
    logic [7:0] eng_rx = '0;

    always #10 clk = ~clk;

    smbus_host_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_op_valid(eng_op_valid), .eng_op(eng_op), .eng_tx(eng_tx),
        .eng_nack(eng_nack), .eng_done(eng_done), .eng_ack(eng_ack), .eng_rx(eng_rx)
    );

    localparam logic [6:0] DEV = 7'h2A;
    localparam logic [7:0] CB  = 8'h20;

    int  checks = 0, errors = 0;
    bit  finished = 0;

    // target model state, driven only by the engine process
    logic [7:0] sm [256];
    logic [7:0] ptr, first_tx;
    bit         sfirst, pend;
    int         nops, nstop, nnack, lat;
    logic [1:0] cop;
    logic [7:0] ctx;
    bit         cnack;
    bit         init_req = 0;
    logic [7:0] init_cnt = '0;

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 7 + 3) & 255);
    endfunction

    always @(negedge clk) begin
        eng_done = 1'b0;
        if (init_req) begin
            for (int i = 0; i < 256; i++) sm[i] = pat(i);
            sm[CB] = init_cnt;
            ptr = 8'h10; sfirst = 0; pend = 0;
            nops = 0; nstop = 0; nnack = 0; first_tx = '0;
        end else if (pend) begin
            if (lat > 0) lat--;
            else begin
                pend = 0;
                eng_done = 1'b1;
                eng_ack = 1'b1;
                case (cop)
                    2'd0: begin
                        if (nops == 0) first_tx = ctx;
                        eng_ack = (ctx[7:1] == DEV);
                        if (eng_ack && !ctx[0]) sfirst = 1;
                    end
                    2'd1: begin
                        if (sfirst) begin ptr = ctx; sfirst = 0; end
                        else begin sm[ptr] = ctx; ptr = ptr + 1; end
                    end
                    2'd2: begin
                        eng_rx = sm[ptr]; ptr = ptr + 1;
                        if (cnack) nnack++;
                    end
                    default: nstop++;
                endcase
                nops++;
            end
        end else if (eng_op_valid) begin
            pend = 1; lat = 2; cop = eng_op; ctx = eng_tx; cnack = eng_nack;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic model_init(input logic [7:0] cnt);
        init_cnt = cnt; init_req = 1;
        @(negedge clk); #1 init_req = 0;
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        for (int k = 0; k < 2000; k++) begin
            rd(4'd0, s);
            if (!s[0]) break;
        end
    endtask

    function automatic int exp_ops(input int p, input int rw, input int pres);
        if (!pres) return 2;
        case (p)
            0: return 2;
            1: return 3;
            2: return rw ? 5 : 4;
            3: return rw ? 6 : 5;
            default: return rw ? 9 : 7;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int pl [5] = '{0, 1, 2, 3, 5};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_init(pat(CB));

        // R1: reset values and the unused offsets
        for (int a = 0; a < 16; a++) begin
            rd(4'(a), v); check("R1 reset read", v, 0);
        end

        // R3: control readback
        wr(4'd2, 8'hA3); rd(4'd2, v); check("R3 ctl readback", v, 8'hA3);
        wr(4'd2, 8'hF0); rd(4'd2, v); check("R3 START dropped", v, 8'hB0);
        rd(4'd0, v); check("R4 code 4 start ignored", v, 0);

        // R4 R5 R6 R7 R9 R10 R12: sweep
        for (int pi = 0; pi < 5; pi++)
        for (int rw = 0; rw < 2; rw++)
        for (int pres = 0; pres < 2; pres++) begin
            int p = pl[pi];
            logic [7:0] d0v = (p == 5) ? 8'd3 : 8'hA5;
            model_init((p == 5 && rw == 1) ? 8'd4 : pat(CB));
            if (p == 5 && rw == 0) begin
                rd(4'd2, v);
                for (int k = 0; k < 3; k++) wr(4'd7, 8'hB0 + 8'(k));
            end
            wr(4'd3, CB);
            wr(4'd4, {pres ? DEV : 7'h33, 1'(rw)});
            wr(4'd5, d0v);
            wr(4'd6, 8'h3C);
            wr(4'd2, 8'h40 | 8'(p << 2));
            rd(4'd0, v); check("R9 busy after start", v, 8'h01);
            wait_idle();
            rd(4'd0, v); check(pres ? "R9 done status" : "R10 device error status", v, pres ? 2 : 4);
            check("R4 engine op count", nops, exp_ops(p, rw, pres));
            check("R10 one stop per run", nstop, 1);
            check("R5 first address byte", first_tx,
                  {pres ? DEV : 7'h33, (p <= 1) ? 1'(rw) : 1'b0});
            if (pres && p != 0) begin
                if (rw) begin
                    check("R12 single nack", nnack, 1);
                    rd(4'd5, v);
                    case (p)
                        1: check("R5 byte read", v, pat(16));
                        2: check("R4 byte-data read", v, pat(CB));
                        3: begin
                            check("R6 word low", v, pat(CB));
                            rd(4'd6, v); check("R6 word high", v, pat(CB + 1));
                        end
                        default: begin
                            check("R7 block count", v, 4);
                            rd(4'd2, v);
                            for (int k = 0; k < 4; k++) begin
                                rd(4'd7, v); check("R7 block read data", v, pat(CB + 1 + k));
                            end
                        end
                    endcase
                end else begin
                    case (p)
                        1: check("R5 byte write", ptr, 8'hA5);
                        2: check("R4 byte-data write", sm[CB], 8'hA5);
                        3: begin
                            check("R6 word low write", sm[CB], 8'hA5);
                            check("R6 word high write", sm[CB + 1], 8'h3C);
                        end
                        default: begin
                            check("R7 block count write", sm[CB], 3);
                            for (int k = 0; k < 3; k++)
                                check("R7 block write data", sm[CB + 1 + k], 8'hB0 + k);
                        end
                    endcase
                end
            end
            // R2: write-one-to-clear
            if (pres && pi == 0 && rw == 0) begin
                wr(4'd0, 8'hE1); rd(4'd0, v); check("R2 zero bits keep status", v, 2);
                wr(4'd0, 8'h02); rd(4'd0, v); check("R2 one clears", v, 0);
            end else begin
                wr(4'd0, 8'hFF); rd(4'd0, v); check("R2 clear all", v, 0);
            end
        end

        // R4: unsupported protocol codes
        for (int c = 4; c < 8; c++) begin
            if (c == 5) continue;
            model_init(pat(CB));
            wr(4'd2, 8'h40 | 8'(c << 2));
            repeat (10) @(negedge clk);
            rd(4'd0, v); check("R4 unsupported status", v, 0);
            check("R4 unsupported no ops", nops, 0);
        end

        // R7: received count above the buffer size
        model_init(8'd40);
        wr(4'd4, {DEV, 1'b1}); wr(4'd2, 8'h54);
        wait_idle();
        check("R7 clamped op count", nops, 37);
        check("R12 clamped single nack", nnack, 1);
        rd(4'd5, v); check("R7 raw count kept", v, 40);
        rd(4'd2, v);
        for (int k = 0; k < 32; k++) begin
            rd(4'd7, v); check("R7 clamped data", v, pat(CB + 1 + k));
        end
        wr(4'd0, 8'hFF);

        // R7: zero-count block write
        model_init(pat(CB));
        wr(4'd4, {DEV, 1'b0}); wr(4'd5, 8'd0); wr(4'd2, 8'h54);
        wait_idle();
        check("R7 zero count ops", nops, 4);
        check("R7 zero count stored", sm[CB], 0);
        wr(4'd0, 8'hFF);

        // R11: control write while busy
        model_init(pat(CB));
        wr(4'd4, {DEV, 1'b1}); wr(4'd2, 8'h48); wr(4'd2, 8'h4C);
        wait_idle();
        rd(4'd2, v); check("R11 ctl unchanged", v, 8'h08);
        check("R11 no second run", nops, 5);
        wr(4'd0, 8'hFF);

        // R8: index wrap and reset by control read
        rd(4'd2, v);
        for (int k = 0; k < 33; k++) wr(4'd7, 8'h10 + 8'(k));
        rd(4'd2, v);
        for (int k = 0; k < 33; k++) begin
            rd(4'd7, v);
            check("R8 wrapped entry", v, (k == 0 || k == 32) ? 8'h30 : 8'h10 + k);
        end

        rd(4'd1, v); check("R1 unused offset", v, 0);
        rd(4'd9, v); check("R1 unused high offset", v, 0);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule